// File: doc/BRIEF.md
# ALU Operand Source and Forwarding Control

This unit sits in the decode stage of a three-stage integer pipeline. It picks the source that drives each ALU input of the instruction being decoded: the register file, the generated immediate, the program counter, or the result of the single older instruction still in flight. That older instruction is the one in the execute stage now. It will be in the write-back stage when the decoded instruction executes, so its result (after load extension) is what gets forwarded. The unit never stalls. Every read-after-write dependency on that one older instruction is resolved by forwarding, and each operand is checked on its own.

The selections are registered at the decode-to-execute boundary, so they apply in the cycle the instruction executes. In that same cycle the unit takes the equal and less-than flags from the execute-stage comparator. It combines them with the registered branch kind to produce the redirect flag for the PC multiplexer. It also drives a flag that tells the comparator to compare unsigned.

Top module: `opsel_ctrl`

## Requirements
- R1: While `rst_n` is low, `a_sel`, `b_sel`, `br_unsigned` and `pc_sel` are all 0, whatever the comparator flags are.
- R2: Decisions for the instruction on `id_instr` appear on `a_sel`, `b_sel` and `br_unsigned` after the next rising clock edge. They stay unchanged until that edge, and `pc_sel` is resolved against that registered instruction.
- R3: Select code 2'b00 means register file, 2'b01 means immediate, 2'b10 means PC, and 2'b11 means the forwarded write-back value.
- R4: The opcode is `id_instr[6:0]` and rs1 is `id_instr[19:15]`. For opcodes 0x33, 0x13, 0x03, 0x23 and 0x67, `a_sel` is 2'b11 when `ex_reg_we` is 1, `ex_rd` is nonzero and `ex_rd` equals rs1. Otherwise `a_sel` is 2'b00.
- R5: rs2 is `id_instr[24:20]`. Only opcode 0x33 forwards on `b_sel`: it gives 2'b11 under the same conditions as R4, applied to rs2, and 2'b00 otherwise. A match on both rs1 and rs2 forwards both operands.
- R6: A destination of register 0, or a clear `ex_reg_we`, never produces the 2'b11 select on either operand.
- R7: Opcodes 0x17, 0x6F and 0x63 select the PC for `a_sel`. Opcodes 0x17, 0x6F, 0x63, 0x13, 0x03, 0x23 and 0x67 select the immediate for `b_sel`.
- R8: Opcode 0x37 selects the immediate on both operands and never forwards, whatever its bits [24:15] hold.
- R9: Any other opcode gives 2'b00 on both selects and never forwards.
- R10: `br_unsigned` is 1 exactly when the instruction is opcode 0x63 with funct3 (`id_instr[14:12]`) equal to 3'b110 or 3'b111.
- R11: `pc_sel` is 1 when the registered instruction is opcode 0x6F or 0x67, regardless of the comparator flags.
- R12: For registered opcode 0x63, `pc_sel` follows funct3. 000 gives `cmp_eq`, 001 gives not `cmp_eq`, 100 and 110 give `cmp_lt`, 101 and 111 give not `cmp_lt`, and 010 and 011 give 0. Every other opcode gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_instr | input | ILEN (32) | Instruction in the decode stage |
| ex_rd | input | REG_AW (5) | Destination register of the instruction in execute |
| ex_reg_we | input | 1 | That instruction writes the register file |
| cmp_eq | input | 1 | Comparator equal flag for the instruction in execute |
| cmp_lt | input | 1 | Comparator less-than flag for the instruction in execute |
| a_sel | output | 2 | Operand A source select |
| b_sel | output | 2 | Operand B source select |
| br_unsigned | output | 1 | Comparator uses unsigned ordering |
| pc_sel | output | 1 | Next PC comes from the ALU result rather than PC+4 |

## Verification
The properties assume that `ex_rd` and `ex_reg_we` describe the instruction that will be in write-back when the decoded one executes. They relate each registered select to the decode inputs one edge earlier. They also assume the comparator flags are valid only while the matching instruction is registered, so `pc_sel` is judged against the registered kind. The stimulus drives every input at the falling edge. It sweeps every opcode class, every funct3, every destination register and both write-enable values, across four rs1/rs2 patterns: both match, only rs1 matches, only rs2 matches, neither matches. It steps the comparator flags through all four combinations, so each input stays stable around the rising edge that registers it.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_AUIPC  = 7'h17;
    localparam logic [6:0] OPC_JAL    = 7'h6F;
    localparam logic [6:0] OPC_JALR   = 7'h67;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_OP     = 7'h33;

    localparam int OPC_LSB = 0;
    localparam int F3_LSB  = 12;
    localparam int RS1_LSB = 15;
    localparam int RS2_LSB = 20;

    typedef enum logic [1:0] {
        SRC_REG = 2'b00,
        SRC_IMM = 2'b01,
        SRC_PC  = 2'b10,
        SRC_FWD = 2'b11
    } src_sel_e;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_JUMP = 3'd1,
        BK_EQ   = 3'd2,
        BK_NE   = 3'd3,
        BK_LT   = 3'd4,
        BK_GE   = 3'd5
    } br_kind_e;

    typedef struct packed {
        src_sel_e a_src;
        src_sel_e b_src;
        logic     rs1_used;
        logic     rs2_used;
        logic     unsigned_cmp;
        br_kind_e kind;
    } decode_t;

    typedef struct packed {
        src_sel_e a_sel;
        src_sel_e b_sel;
        logic     br_unsigned;
        br_kind_e kind;
    } ctrl_t;

endpackage

// File: rtl/opsel_decode.sv
module opsel_decode
    import opsel_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    output decode_t    dec
);

    br_kind_e cond_kind;

    // Branch condition family from funct3; 010/011 are not defined branches.
    always_comb begin
        case (funct3)
            3'b000:          cond_kind = BK_EQ;
            3'b001:          cond_kind = BK_NE;
            3'b100, 3'b110:  cond_kind = BK_LT;
            3'b101, 3'b111:  cond_kind = BK_GE;
            default:         cond_kind = BK_NONE;
        endcase
    end

    always_comb begin
        dec              = '0;
        dec.a_src        = SRC_REG;
        dec.b_src        = SRC_REG;
        dec.kind         = BK_NONE;
        case (opcode)
            OPC_OP: begin
                dec.rs1_used = 1'b1;
                dec.rs2_used = 1'b1;
            end
            OPC_OPIMM, OPC_LOAD, OPC_STORE: begin
                dec.rs1_used = 1'b1;
                dec.b_src    = SRC_IMM;
            end
            OPC_JALR: begin
                dec.rs1_used = 1'b1;
                dec.b_src    = SRC_IMM;
                dec.kind     = BK_JUMP;
            end
            OPC_JAL: begin
                dec.a_src    = SRC_PC;
                dec.b_src    = SRC_IMM;
                dec.kind     = BK_JUMP;
            end
            OPC_AUIPC: begin
                dec.a_src    = SRC_PC;
                dec.b_src    = SRC_IMM;
            end
            OPC_BRANCH: begin
                dec.a_src        = SRC_PC;
                dec.b_src        = SRC_IMM;
                dec.kind         = cond_kind;
                dec.unsigned_cmp = (funct3[2:1] == 2'b11);
            end
            OPC_LUI: begin
                dec.a_src    = SRC_IMM;
                dec.b_src    = SRC_IMM;
            end
            default: begin
                dec.a_src    = SRC_REG;
                dec.b_src    = SRC_REG;
            end
        endcase
    end

endmodule

// File: rtl/opsel_fwd_match.sv
module opsel_fwd_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] src_addr,
    input  logic [NUM_SRC-1:0]             src_used,
    input  logic [REG_AW-1:0]              wb_addr,
    input  logic                           wb_en,
    output logic [NUM_SRC-1:0]             hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic producer_live;

    // A producer that writes register 0 or does not write at all feeds nothing.
    assign producer_live = wb_en && (wb_addr != ZERO_REG);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = producer_live && src_used[g] && (src_addr[g] == wb_addr);
    end

endmodule

// File: rtl/opsel_redirect.sv
module opsel_redirect
    import opsel_pkg::*;
(
    input  br_kind_e kind,
    input  logic     cmp_eq,
    input  logic     cmp_lt,
    output logic     take
);

    always_comb begin
        case (kind)
            BK_JUMP: take = 1'b1;
            BK_EQ:   take = cmp_eq;
            BK_NE:   take = !cmp_eq;
            BK_LT:   take = cmp_lt;
            BK_GE:   take = !cmp_lt;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/opsel_ctrl.sv
module opsel_ctrl
    import opsel_pkg::*;
#(
    parameter int ILEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ILEN-1:0]   id_instr,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_reg_we,
    input  logic              cmp_eq,
    input  logic              cmp_lt,
    output logic [1:0]        a_sel,
    output logic [1:0]        b_sel,
    output logic              br_unsigned,
    output logic              pc_sel
);

    localparam int NUM_SRC = 2;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;

    decode_t                           dec;
    logic [NUM_SRC-1:0][REG_AW-1:0]    src_addr;
    logic [NUM_SRC-1:0]                src_used;
    logic [NUM_SRC-1:0]                hit;
    ctrl_t                             ctrl_d;
    ctrl_t                             ctrl_q;
    logic                              unused_bits;

    assign unused_bits = ^{id_instr[ILEN-1:RS2_LSB+REG_AW], id_instr[F3_LSB-1:7]};

    opsel_decode i_decode (
        .opcode (id_instr[OPC_LSB +: 7]),
        .funct3 (id_instr[F3_LSB +: 3]),
        .dec    (dec)
    );

    assign src_addr[IDX_A] = id_instr[RS1_LSB +: REG_AW];
    assign src_addr[IDX_B] = id_instr[RS2_LSB +: REG_AW];
    assign src_used[IDX_A] = dec.rs1_used;
    assign src_used[IDX_B] = dec.rs2_used;

    opsel_fwd_match #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) i_fwd_match (
        .src_addr (src_addr),
        .src_used (src_used),
        .wb_addr  (ex_rd),
        .wb_en    (ex_reg_we),
        .hit      (hit)
    );

    always_comb begin
        ctrl_d             = ctrl_q;
        ctrl_d.a_sel       = hit[IDX_A] ? SRC_FWD : dec.a_src;
        ctrl_d.b_sel       = hit[IDX_B] ? SRC_FWD : dec.b_src;
        ctrl_d.br_unsigned = dec.unsigned_cmp;
        ctrl_d.kind        = dec.kind;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{a_sel: SRC_REG, b_sel: SRC_REG, br_unsigned: 1'b0, kind: BK_NONE};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    opsel_redirect i_redirect (
        .kind   (ctrl_q.kind),
        .cmp_eq (cmp_eq),
        .cmp_lt (cmp_lt),
        .take   (pc_sel)
    );

    assign a_sel       = ctrl_q.a_sel;
    assign b_sel       = ctrl_q.b_sel;
    assign br_unsigned = ctrl_q.br_unsigned;

endmodule

// File: rtl/opsel_ctrl_checker.sv
module opsel_ctrl_checker #(
    parameter int ILEN   = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ILEN-1:0]   id_instr,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_reg_we,
    input logic [1:0]        a_sel,
    input logic [1:0]        b_sel,
    input logic              br_unsigned,
    input logic              pc_sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // R1: a cycle spent in reset leaves every registered select cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (a_sel == 2'b00 && b_sel == 2'b00 && !br_unsigned));

    // R4: a forwarded A operand names the producer's destination.
    p_fwd_a_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel == 2'b11) |-> ($past(id_instr[19:15]) == $past(ex_rd)));

    // R5: only register-register instructions forward on operand B.
    p_fwd_b_op_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel == 2'b11) |-> ($past(id_instr[6:0]) == 7'h33
                              && $past(id_instr[24:20]) == $past(ex_rd)));

    // R6: a silent or register-0 producer never feeds an operand.
    p_no_fwd_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ex_rd) == ZERO_REG || !$past(ex_reg_we))
            |-> (a_sel != 2'b11 && b_sel != 2'b11));

    // R7: a PC operand is always paired with an immediate.
    p_pc_with_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel == 2'b10) |-> (b_sel == 2'b01));

    // R10: unsigned comparison only for branches.
    p_unsigned_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        br_unsigned |-> ($past(id_instr[6:0]) == 7'h63 && $past(id_instr[14:13]) == 2'b11));

    // R12: a redirect comes from a PC-relative flow change or a register jump.
    p_redirect_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |-> (a_sel == 2'b10 || $past(id_instr[6:0]) == 7'h67));

endmodule

bind opsel_ctrl opsel_ctrl_checker #(
    .ILEN   (ILEN),
    .REG_AW (REG_AW)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_instr    (id_instr),
    .ex_rd       (ex_rd),
    .ex_reg_we   (ex_reg_we),
    .a_sel       (a_sel),
    .b_sel       (b_sel),
    .br_unsigned (br_unsigned),
    .pc_sel      (pc_sel)
);

// File: tb/test_opsel_ctrl.sv
module test_opsel_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] id_instr;
    logic [4:0]  ex_rd;
    logic        ex_reg_we;
    logic        cmp_eq;
    logic        cmp_lt;
    logic [1:0]  a_sel;
    logic [1:0]  b_sel;
    logic        br_unsigned;
    logic        pc_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    opsel_ctrl i_opsel_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_instr    (id_instr),
        .ex_rd       (ex_rd),
        .ex_reg_we   (ex_reg_we),
        .cmp_eq      (cmp_eq),
        .cmp_lt      (cmp_lt),
        .a_sel       (a_sel),
        .b_sel       (b_sel),
        .br_unsigned (br_unsigned),
        .pc_sel      (pc_sel)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] opc_of(input int i);
        case (i)
            0:  return 7'h37;
            1:  return 7'h17;
            2:  return 7'h6F;
            3:  return 7'h67;
            4:  return 7'h63;
            5:  return 7'h03;
            6:  return 7'h23;
            7:  return 7'h13;
            8:  return 7'h33;
            9:  return 7'h73;
            10: return 7'h0F;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic live_match(input logic [4:0] rs, input logic [4:0] rd, input logic we);
        return we && (rd != 5'd0) && (rs == rd);
    endfunction

    // Expected A select per R4, R7, R8, R9 with encoding of R3.
    function automatic logic [1:0] exp_a(input logic [6:0] op, input logic [4:0] rs1,
                                         input logic [4:0] rd, input logic we);
        if (op == 7'h33 || op == 7'h13 || op == 7'h03 || op == 7'h23 || op == 7'h67)
            return live_match(rs1, rd, we) ? 2'b11 : 2'b00;
        if (op == 7'h17 || op == 7'h6F || op == 7'h63) return 2'b10;
        if (op == 7'h37) return 2'b01;
        return 2'b00;
    endfunction

    // Expected B select per R5, R7, R8, R9.
    function automatic logic [1:0] exp_b(input logic [6:0] op, input logic [4:0] rs2,
                                         input logic [4:0] rd, input logic we);
        if (op == 7'h33) return live_match(rs2, rd, we) ? 2'b11 : 2'b00;
        if (op == 7'h17 || op == 7'h6F || op == 7'h63 || op == 7'h13 || op == 7'h03
            || op == 7'h23 || op == 7'h67 || op == 7'h37) return 2'b01;
        return 2'b00;
    endfunction

    // Expected redirect per R11, R12.
    function automatic logic exp_pc(input logic [6:0] op, input logic [2:0] f3,
                                    input logic eq, input logic lt);
        if (op == 7'h6F || op == 7'h67) return 1'b1;
        if (op != 7'h63) return 1'b0;
        if (f3 == 3'b000) return eq;
        if (f3 == 3'b001) return !eq;
        if (f3 == 3'b100 || f3 == 3'b110) return lt;
        if (f3 == 3'b101 || f3 == 3'b111) return !lt;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] pa, pb;
        logic       pu;
        logic [6:0] pop;
        logic [2:0] pf3;
        int         step;

        rst_n     = 1'b0;
        id_instr  = 32'h0000_0033;
        ex_rd     = 5'd1;
        ex_reg_we = 1'b1;
        cmp_eq    = 1'b0;
        cmp_lt    = 1'b0;
        repeat (3) @(negedge clk);

        // R1: cleared outputs in reset, pc_sel quiet for every flag pair.
        for (int c = 0; c < 4; c++) begin
            cmp_eq = c[0];
            cmp_lt = c[1];
            #1;
            check("R1 a_sel", {2'b0, a_sel}, 4'h0);
            check("R1 b_sel", {2'b0, b_sel}, 4'h0);
            check("R1 br_unsigned", {3'b0, br_unsigned}, 4'h0);
            check("R1 pc_sel", {3'b0, pc_sel}, 4'h0);
            @(negedge clk);
        end

        pa = 2'b00; pb = 2'b00; pu = 1'b0; pop = 7'h00; pf3 = 3'b000;
        id_instr = 32'h0;
        rst_n    = 1'b1;
        step     = 0;

        for (int oi = 0; oi < 12; oi++) begin
            for (int f = 0; f < 8; f++) begin
                for (int we = 0; we < 2; we++) begin
                    for (int rd = 0; rd < 32; rd++) begin
                        for (int m = 0; m < 4; m++) begin
                            logic [4:0] rdv, other, rs1, rs2;
                            logic [6:0] op;
                            logic       eq, lt;
                            rdv   = rd[4:0];
                            other = rdv + 5'd9;
                            rs1   = m[0] ? other : rdv;
                            rs2   = m[1] ? other : rdv;
                            op    = opc_of(oi);
                            eq    = step[0];
                            lt    = step[1];
                            // Flags belong to the registered (previous) instruction.
                            cmp_eq    = eq;
                            cmp_lt    = lt;
                            id_instr  = {7'h55, rs2, rs1, f[2:0], 5'd7, op};
                            ex_rd     = rdv;
                            ex_reg_we = we[0];
                            #1;
                            // R2: new decode not visible before the edge.
                            check("R2/R4 a_sel", {2'b0, a_sel}, {2'b0, pa});
                            check("R2/R5 b_sel", {2'b0, b_sel}, {2'b0, pb});
                            check("R10 br_unsigned", {3'b0, br_unsigned}, {3'b0, pu});
                            check("R11/R12 pc_sel", {3'b0, pc_sel},
                                  {3'b0, exp_pc(pop, pf3, eq, lt)});
                            pa  = exp_a(op, rs1, rdv, we[0]);
                            pb  = exp_b(op, rs2, rdv, we[0]);
                            pu  = (op == 7'h63) && (f[2:1] == 2'b11);
                            pop = op;
                            pf3 = f[2:0];
                            step++;
                            @(negedge clk);
                        end
                    end
                end
            end
        end

        // Final registered instruction.
        cmp_eq = 1'b1;
        cmp_lt = 1'b0;
        #1;
        check("R3/R4 a_sel", {2'b0, a_sel}, {2'b0, pa});
        check("R3/R5 b_sel", {2'b0, b_sel}, {2'b0, pb});
        check("R10 br_unsigned", {3'b0, br_unsigned}, {3'b0, pu});
        check("R12 pc_sel", {3'b0, pc_sel}, {3'b0, exp_pc(pop, pf3, 1'b1, 1'b0)});

        // R6 and R8 corner: LUI with rs fields equal to a live producer.
        id_instr  = {7'h00, 5'd3, 5'd3, 3'b000, 5'd3, 7'h37};
        ex_rd     = 5'd3;
        ex_reg_we = 1'b1;
        @(negedge clk);
        #1;
        check("R8 lui a_sel", {2'b0, a_sel}, 4'h1);
        check("R8 lui b_sel", {2'b0, b_sel}, 4'h1);

        // R5 and R6: both operands forwarded, then register 0 producer.
        id_instr = {7'h00, 5'd3, 5'd3, 3'b000, 5'd4, 7'h33};
        @(negedge clk);
        #1;
        check("R5 both a_sel", {2'b0, a_sel}, 4'h3);
        check("R5 both b_sel", {2'b0, b_sel}, 4'h3);
        id_instr = {7'h00, 5'd0, 5'd0, 3'b000, 5'd4, 7'h33};
        ex_rd    = 5'd0;
        @(negedge clk);
        #1;
        check("R6 x0 a_sel", {2'b0, a_sel}, 4'h0);
        check("R6 x0 b_sel", {2'b0, b_sel}, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule